// File: doc/BRIEF.md
# Windowed Overlay Shadow Register Controller

This block keeps the programming state of five overlay windows in two copies. Software writes and reads a shadow copy through a simple register port. The display pipeline sees only an active copy. Each window's shadow words move into its active copy on the clock edge where a vsync pulse is present. That edge is also where the pipeline starts fetching a new frame, so a frame never sees a half-updated window.

A shared control register holds two bits per window: a DMA channel enable and a protect bit. While a window is protected, its vsync transfer is skipped. Software can therefore rewrite several words of that window across any number of frames, clear protect, and have all of the words land together at the next vsync. The words themselves are opaque to the block; the only field it interprets is a window enable bit in each window's first word. Blending and pixel fetch belong to other blocks.

The address map places window `w`, word `r` at address `w*4 + r`, which gives addresses 0 to 19. The control register is at address 20. Addresses 21 to 31 are unmapped.

Top module: `win_shadow_regs`

## Requirements
- R1: While reset is low, and after reset is released, every shadow word, active word, protect bit and channel-enable bit is zero. All outputs therefore read zero.
- R2: A write with `we_i` high to address `w*4+r` (r in 0..3, w in 0..4) updates that shadow word on the same clock edge. `rdata_o` for that address returns the shadow word combinationally. The active copy does not change on any edge without `vsync_i`.
- R3: On an edge with `vsync_i` high, every window whose protect bit is clear copies all four shadow words into its active words. The copied values are visible on `act_regs_o` at bits `(w*4+r)*32 +: 32` after that edge.
- R4: On an edge with `vsync_i` high, a window whose protect bit is set keeps all four active words unchanged. Other windows still transfer on that edge.
- R5: Shadow values written while a window is protected are committed at the first vsync after its protect bit has been cleared.
- R6: The control register at address 20 holds channel enables in bits 4:0 and protect bits in bits 20:16, with bit `w` and bit `16+w` belonging to window `w`. Writes take effect on the next edge and are not deferred. `chan_en_o` shows the channel enables, and reads of address 20 return these bits with all other bits zero.
- R7: `win_en_o[w]` is bit 0 of window `w`'s active word 0. Writing 0 to that bit under protect leaves the window enabled until the first vsync after unprotect.
- R8: Writes to addresses 21..31, and to the control window at nonzero word offsets, change no state. Reads of those addresses return zero.
- R9: When a shadow write and a vsync fall on the same edge, the active copy takes the shadow value held before the write. The new value commits at the following vsync.
- R10: When a control write and a vsync fall on the same edge, the vsync is gated by the protect bits held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| vsync_i | input | 1 | One-cycle frame-start pulse |
| chan_en_o | output | 5 | Per-window DMA channel enable |
| win_en_o | output | 5 | Per-window active enable bit |
| act_regs_o | output | 640 | Active words of all windows, window-major, 32 bits each |

## Verification
The bench targets the edges where two events meet.

- A shadow write landing on a vsync edge: a design that forwards the new value would commit it one frame early.
- A control write that clears protect on a vsync edge: a design that gates with the new protect value would let a protected window leak a partial update.
- A protected window next to unprotected ones: a protect bit decoded to the wrong window would hold or release the wrong bank.
- A disable made under protect: `win_en_o` should drop only one vsync after unprotect.
- Unmapped writes: these must leave every readable word and every active output untouched.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WIN  = 2'd1,
    ACC_CTRL = 2'd2
  } acc_e;
endpackage

// File: rtl/wsr_addr_dec.sv
module wsr_addr_dec import wsr_pkg::*; #(
  parameter int unsigned NWIN   = 5,
  parameter int unsigned NREG   = 4,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned RIDX_W = $clog2(NREG),
  parameter int unsigned WSEL_W = ADDR_W - RIDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              kind_o,
  output logic [WSEL_W-1:0] wsel_o,
  output logic [RIDX_W-1:0] ridx_o
);
  localparam logic [WSEL_W-1:0] CTRL_SEL = WSEL_W'(NWIN);

  always_comb begin
    wsel_o = addr_i[ADDR_W-1:RIDX_W];
    ridx_o = addr_i[RIDX_W-1:0];
    if (wsel_o < CTRL_SEL)                      kind_o = ACC_WIN;
    else if (wsel_o == CTRL_SEL && ridx_o == '0) kind_o = ACC_CTRL;
    else                                         kind_o = ACC_NONE;
  end
endmodule

// File: rtl/wsr_win_bank.sv
module wsr_win_bank #(
  parameter int unsigned NREG   = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned RIDX_W = $clog2(NREG),
  parameter int unsigned EN_BIT = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [RIDX_W-1:0]  ridx_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               xfer_i,
  output logic [NREG*DW-1:0] shd_o,
  output logic [NREG*DW-1:0] act_o,
  output logic               en_o
);
  logic [NREG-1:0][DW-1:0] shd_q, act_q;

  // transfer samples pre-write shadow: same-edge write lands next frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (xfer_i) act_q <= shd_q;
      if (wr_i)   shd_q[ridx_i] <= wdata_i;
    end
  end

  assign shd_o = shd_q;
  assign act_o = act_q;
  assign en_o  = act_q[0][EN_BIT];
endmodule

// File: rtl/wsr_ctrl_reg.sv
module wsr_ctrl_reg #(
  parameter int unsigned NWIN     = 5,
  parameter int unsigned DW       = 32,
  parameter int unsigned PROT_LSB = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NWIN-1:0] chan_d_i,
  input  logic [NWIN-1:0] prot_d_i,
  output logic [NWIN-1:0] chan_o,
  output logic [NWIN-1:0] prot_o,
  output logic [DW-1:0]   rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o <= '0;
      prot_o <= '0;
    end else if (wr_i) begin
      chan_o <= chan_d_i;
      prot_o <= prot_d_i;
    end
  end

  always_comb begin
    rd_o = '0;
    rd_o[NWIN-1:0]         = chan_o;
    rd_o[PROT_LSB +: NWIN] = prot_o;
  end
endmodule

// File: rtl/wsr_rd_mux.sv
module wsr_rd_mux import wsr_pkg::*; #(
  parameter int unsigned NWIN   = 5,
  parameter int unsigned NREG   = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  acc_e                   kind_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NWIN*NREG*DW-1:0] shd_all_i,
  input  logic [DW-1:0]          ctrl_rd_i,
  output logic [DW-1:0]          rdata_o
);
  // window words sit at flat index == address
  always_comb begin
    unique case (kind_i)
      ACC_WIN:  rdata_o = shd_all_i[DW*int'(addr_i) +: DW];
      ACC_CTRL: rdata_o = ctrl_rd_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/win_shadow_regs.sv
module win_shadow_regs import wsr_pkg::*; #(
  parameter int unsigned NWIN     = 5,
  parameter int unsigned NREG     = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned PROT_LSB = 16,
  parameter int unsigned EN_BIT   = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  input  logic                    vsync_i,
  output logic [NWIN-1:0]         chan_en_o,
  output logic [NWIN-1:0]         win_en_o,
  output logic [NWIN*NREG*DW-1:0] act_regs_o
);
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned WSEL_W = ADDR_W - RIDX_W;
  localparam int unsigned BANK_W = NREG * DW;

  acc_e                    kind;
  logic [WSEL_W-1:0]       wsel;
  logic [RIDX_W-1:0]       ridx;
  logic [NWIN-1:0]         prot_q;
  logic [DW-1:0]           ctrl_rd;
  logic [NWIN*BANK_W-1:0]  shd_all;

  wsr_addr_dec #(
    .NWIN(NWIN), .NREG(NREG), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .WSEL_W(WSEL_W)
  ) i_dec (
    .addr_i(addr_i), .kind_o(kind), .wsel_o(wsel), .ridx_o(ridx)
  );

  wsr_ctrl_reg #(.NWIN(NWIN), .DW(DW), .PROT_LSB(PROT_LSB)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && kind == ACC_CTRL),
    .chan_d_i(wdata_i[NWIN-1:0]),
    .prot_d_i(wdata_i[PROT_LSB +: NWIN]),
    .chan_o  (chan_en_o),
    .prot_o  (prot_q),
    .rd_o    (ctrl_rd)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic wr_w, xfer_w;
    assign wr_w   = we_i && kind == ACC_WIN && wsel == WSEL_W'(w);
    assign xfer_w = vsync_i && !prot_q[w];

    wsr_win_bank #(.NREG(NREG), .DW(DW), .RIDX_W(RIDX_W), .EN_BIT(EN_BIT)) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_w),
      .ridx_i (ridx),
      .wdata_i(wdata_i),
      .xfer_i (xfer_w),
      .shd_o  (shd_all[w*BANK_W +: BANK_W]),
      .act_o  (act_regs_o[w*BANK_W +: BANK_W]),
      .en_o   (win_en_o[w])
    );
  end

  wsr_rd_mux #(.NWIN(NWIN), .NREG(NREG), .DW(DW), .ADDR_W(ADDR_W)) i_rd (
    .kind_i   (kind),
    .addr_i   (addr_i),
    .shd_all_i(shd_all),
    .ctrl_rd_i(ctrl_rd),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/win_shadow_regs_chk.sv
module win_shadow_regs_chk #(
  parameter int unsigned NWIN   = 5,
  parameter int unsigned NREG   = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    vsync_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [NWIN-1:0]         wchan_i,
  input logic [DW-1:0]           rdata_i,
  input logic [NWIN*NREG*DW-1:0] act_i,
  input logic [NWIN*NREG*DW-1:0] shd_i,
  input logic [NWIN-1:0]         prot_i,
  input logic [NWIN-1:0]         chan_i,
  input logic [NWIN-1:0]         win_en_i
);
  localparam int unsigned BANK_W = NREG * DW;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NWIN * NREG);

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(act_i));

  p_en_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(win_en_i));

  p_ctrl_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CTRL_ADDR) |=> chan_i == $past(wchan_i));

  p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > CTRL_ADDR) |-> rdata_i == '0);

  for (genvar w = 0; w < NWIN; w++) begin : g_w
    p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vsync_i && !prot_i[w]) |=> act_i[w*BANK_W +: BANK_W] == $past(shd_i[w*BANK_W +: BANK_W]));

    p_protect_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vsync_i && prot_i[w]) |=> $stable(act_i[w*BANK_W +: BANK_W]));
  end
endmodule

bind win_shadow_regs win_shadow_regs_chk #(
  .NWIN(NWIN), .NREG(NREG), .DW(DW), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vsync_i (vsync_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wchan_i (wdata_i[NWIN-1:0]),
  .rdata_i (rdata_o),
  .act_i   (act_regs_o),
  .shd_i   (shd_all),
  .prot_i  (prot_q),
  .chan_i  (chan_en_o),
  .win_en_i(win_en_o)
);

// File: tb/test_win_shadow_regs.sv
`timescale 1ns/1ps
module test_win_shadow_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        vsync_i = 1'b0;
  logic [31:0] rdata_o;
  logic [4:0]  chan_en_o, win_en_o;
  logic [639:0] act_regs_o;

  always #2.5 clk = ~clk;

  win_shadow_regs i_win_shadow_regs (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .vsync_i(vsync_i), .chan_en_o(chan_en_o),
    .win_en_o(win_en_o), .act_regs_o(act_regs_o)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  logic [31:0] m_shd [5][4];
  logic [31:0] m_act [5][4];
  logic [4:0]  m_prot = '0, m_chan = '0;

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic model_edge();
    if (vsync_i)
      for (int w = 0; w < 5; w++)
        if (!m_prot[w])
          for (int r = 0; r < 4; r++) m_act[w][r] = m_shd[w][r];
    if (we_i) begin
      if (addr_i < 5'd20) m_shd[addr_i / 4][addr_i % 4] = wdata_i;
      else if (addr_i == 5'd20) begin
        m_chan = wdata_i[4:0];
        m_prot = wdata_i[20:16];
      end
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    if (a < 5'd20) return m_shd[a / 4][a % 4];
    if (a == 5'd20) return {11'd0, m_prot, 11'd0, m_chan};
    return 32'd0;
  endfunction

  task automatic compare_all();
    for (int w = 0; w < 5; w++) begin
      for (int r = 0; r < 4; r++)
        chk($sformatf("act w%0d r%0d", w, r), act_regs_o[(w*4+r)*32 +: 32], m_act[w][r]);
    end
    chk("win_en", {27'd0, win_en_o},
        {27'd0, m_act[4][0][0], m_act[3][0][0], m_act[2][0][0], m_act[1][0][0], m_act[0][0][0]});
    chk("chan_en", {27'd0, chan_en_o}, {27'd0, m_chan});
    chk($sformatf("rdata a%0d", addr_i), rdata_o, exp_rd(addr_i));
  endtask

  task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d, input logic vs);
    we_i = we; addr_i = a; wdata_i = d; vsync_i = vs;
    @(posedge clk);
    if (rst_ni) model_edge();
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [31:0] ctl(input logic [4:0] prot, input logic [4:0] chan);
    return {11'd0, prot, 11'd0, chan};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int w = 0; w < 5; w++)
      for (int r = 0; r < 4; r++) begin
        m_shd[w][r] = '0;
        m_act[w][r] = '0;
      end
    // R1: reset state, including a write attempted during reset
    cur_req = "R1";
    step(1'b1, 5'd3, 32'hDEAD_BEEF, 1'b1);
    step(1'b0, 5'd3, 32'h0, 1'b0);
    rst_ni = 1'b1;
    step(1'b0, 5'd20, 32'h0, 1'b0);

    cur_req = "R2";
    step(1'b1, 5'd0, 32'hA0A0_0001, 1'b0);
    step(1'b1, 5'd1, 32'hA0A0_0002, 1'b0);
    step(1'b1, 5'd2, 32'hA0A0_0003, 1'b0);
    step(1'b1, 5'd19, 32'h4444_0004, 1'b0);
    step(1'b0, 5'd1, 32'h0, 1'b0);
    step(1'b0, 5'd19, 32'h0, 1'b0);

    cur_req = "R3";
    step(1'b0, 5'd0, 32'h0, 1'b1);
    step(1'b0, 5'd2, 32'h0, 1'b0);

    cur_req = "R6";
    step(1'b1, 5'd20, ctl(5'b00100, 5'b10101), 1'b0);
    step(1'b0, 5'd20, 32'h0, 1'b0);

    cur_req = "R4";
    step(1'b1, 5'd9, 32'h2222_0009, 1'b0);
    step(1'b1, 5'd2, 32'h0000_5555, 1'b0);
    step(1'b0, 5'd9, 32'h0, 1'b1);
    step(1'b0, 5'd9, 32'h0, 1'b1);

    cur_req = "R5";
    step(1'b1, 5'd20, ctl(5'b00000, 5'b10101), 1'b0);
    step(1'b0, 5'd9, 32'h0, 1'b0);
    step(1'b0, 5'd9, 32'h0, 1'b1);

    cur_req = "R7";
    step(1'b1, 5'd4, 32'h0000_0001, 1'b0);
    step(1'b0, 5'd4, 32'h0, 1'b1);
    step(1'b1, 5'd20, ctl(5'b00010, 5'b00010), 1'b0);
    step(1'b1, 5'd4, 32'h0000_0000, 1'b0);
    step(1'b0, 5'd4, 32'h0, 1'b1);
    step(1'b1, 5'd20, ctl(5'b00000, 5'b00010), 1'b0);
    step(1'b0, 5'd4, 32'h0, 1'b0);
    step(1'b0, 5'd4, 32'h0, 1'b1);

    cur_req = "R8";
    step(1'b1, 5'd21, 32'hFFFF_FFFF, 1'b0);
    step(1'b1, 5'd31, 32'hFFFF_FFFF, 1'b0);
    step(1'b1, 5'd23, 32'hFFFF_FFFF, 1'b1);
    step(1'b0, 5'd21, 32'h0, 1'b0);
    step(1'b0, 5'd27, 32'h0, 1'b0);
    step(1'b0, 5'd20, 32'h0, 1'b0);

    cur_req = "R9";
    step(1'b1, 5'd3, 32'h9999_0003, 1'b1);
    step(1'b0, 5'd3, 32'h0, 1'b0);
    step(1'b0, 5'd3, 32'h0, 1'b1);

    cur_req = "R10";
    step(1'b1, 5'd20, ctl(5'b01000, 5'b01000), 1'b0);
    step(1'b1, 5'd12, 32'h3333_000C, 1'b0);
    step(1'b1, 5'd20, ctl(5'b00000, 5'b01000), 1'b1);
    step(1'b0, 5'd12, 32'h0, 1'b0);
    step(1'b1, 5'd20, ctl(5'b10000, 5'b11111), 1'b1);
    step(1'b0, 5'd12, 32'h0, 1'b1);

    cur_req = "R4";
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      logic [31:0] d;
      a = 5'($urandom_range(0, 31));
      d = $urandom;
      step(($urandom_range(0, 1) == 1), a, d, ($urandom_range(0, 3) == 0));
    end

    summary();
    $finish;
  end
endmodule